// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy super I/O function. Software reaches it over an 8-bit I/O bus (address, write strobe, read strobe, write data, read data). Two adjacent I/O addresses form the window: the lower one takes the unlock and lock keys and the register index, and the upper one reads and writes the register that the index points at.

Everything behind the window stays hidden until a two-byte key is written to the lower address, and one exit byte hides it again. Once the window is open, software can program the global registers: a soft reset, two power-down control bytes, and a logical-device selector. It can also program a bank that belongs to one parallel-port logical device, holding its enable bit, its 16-bit I/O base and its protocol mode byte. The block drives the enable, base and mode of that device to the rest of the chip.

Top module: `sio_cfg_port`

## Requirements
- R1: After hardware reset the window is locked, the index and logical-device selector are 0x00, `lptEnable` is 0, `lptBase` is 0x0378 and `lptMode` is 0x00.
- R2: The window opens only when 0x51 and then 0x23 are written as consecutive writes to address 0x3F0; accesses to other addresses do not break the pair. After 0x51, any other byte returns to the start, except 0x51 itself, which arms the pair again.
- R3: While the window is open, writing 0xBB to 0x3F0 locks it and leaves the index unchanged.
- R4: While the window is locked, writes to 0x3F1 change nothing, and reads of 0x3F0 or 0x3F1 return 0xFF.
- R5: While the window is open, a write to 0x3F0 (other than 0xBB) sets the index, a read of 0x3F0 returns the index, and reads and writes at 0x3F1 reach the indexed register.
- R6: Index 0x07 is an 8-bit read/write logical-device selector.
- R7: The device bank answers only while the selector holds 0x03. Bit 0 of index 0x30 is the device enable, drives `lptEnable`, and reads back with bits 7:1 as zero. With any other selector value, bank indices read 0x00 and writes to them are ignored.
- R8: Indices 0x60 and 0x61 hold the high and low bytes of the device base, and `lptBase` is {high, low}.
- R9: Index 0xF0 holds the mode byte, which drives `lptMode` (0x8F is the combined extended/enhanced mode).
- R10: Indices 0x22 (direct power-down) and 0x23 (automatic power-down) are 8-bit read/write registers that reset to 0x00.
- R11: A write to index 0x02 with bit 0 set raises a pending bit, which reads back as bit 0 of index 0x02. At the next clock, every configuration register returns to its reset value and the bit clears. The lock state and the index are kept. A write to index 0x02 with bit 0 clear has no effect.
- R12: Indices not listed above read 0x00, and writes to them have no effect.
- R13: `ioRdData` is 0x00 when no read strobe is active or when the read address is neither 0x3F0 nor 0x3F1. Read data is combinational in the same cycle as `ioRd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, valid while `ioRd` is high |
| lptEnable | output | 1 | Parallel-port device enable |
| lptBase | output | 16 | Parallel-port device I/O base |
| lptMode | output | 8 | Parallel-port protocol mode byte |

## Verification
The assertions assume that `ioWr` and `ioRd` are never high in the same cycle, that each write lasts one clock, and that no second soft-reset write lands in the cycle where a reset is pending. The bench drives each access alone in its own cycle. After every soft-reset write it inserts an idle cycle before the next access. Random traffic sends unlock pairs, broken pairs, exit bytes and index/data writes from a weighted pool, so the locked and open states are both visited many times while the bus rules still hold.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lockState_t;

  // write strobes from control to the register bank
  typedef struct packed {
    logic ldn;
    logic pwrDir;
    logic pwrAuto;
    logic softRst;
    logic devEn;
    logic baseHi;
    logic baseLo;
    logic devMode;
  } regStb_t;

  localparam logic [7:0] IDX_SOFTRST = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_PWRDIR  = 8'h22;
  localparam logic [7:0] IDX_PWRAUTO = 8'h23;
  localparam logic [7:0] IDX_DEVEN   = 8'h30;
  localparam logic [7:0] IDX_BASEHI  = 8'h60;
  localparam logic [7:0] IDX_BASELO  = 8'h61;
  localparam logic [7:0] IDX_MODE    = 8'hF0;

  localparam int NUM_PWR = 2;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT = 16'h03F0,
  parameter logic [7:0]       KEY_A    = 8'h51,
  parameter logic [7:0]       KEY_B    = 8'h23,
  parameter logic [7:0]       KEY_EXIT = 8'hBB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  input  logic              devSel,
  output regStb_t           stb,
  output logic              unlocked,
  output logic              cfgRead,
  output logic              dataRead,
  output logic [7:0]        index
);

  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(CFG_PORT + 1);

  lockState_t lockQ, lockD;
  logic [7:0] idxQ;
  logic       cfgHit, dataHit, cfgWr, dataWr;

  assign cfgHit  = (ioAddr == CFG_PORT);
  assign dataHit = (ioAddr == DATA_PORT);
  assign cfgWr   = ioWr && cfgHit;

  always_comb begin
    lockD = lockQ;
    if (cfgWr) begin
      case (lockQ)
        LK_LOCKED: lockD = (ioWrData == KEY_A) ? LK_ARMED : LK_LOCKED;
        LK_ARMED: begin
          if (ioWrData == KEY_B)      lockD = LK_OPEN;
          else if (ioWrData == KEY_A) lockD = LK_ARMED;
          else                        lockD = LK_LOCKED;
        end
        LK_OPEN:   lockD = (ioWrData == KEY_EXIT) ? LK_LOCKED : LK_OPEN;
        default:   lockD = LK_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= LK_LOCKED;
      idxQ  <= 8'h00;
    end else begin
      lockQ <= lockD;
      if (cfgWr && lockQ == LK_OPEN && ioWrData != KEY_EXIT)
        idxQ <= ioWrData;
    end
  end

  assign unlocked = (lockQ == LK_OPEN);
  assign index    = idxQ;
  assign cfgRead  = ioRd && cfgHit;
  assign dataRead = ioRd && dataHit;
  assign dataWr   = ioWr && dataHit && unlocked;

  always_comb begin
    stb         = '0;
    stb.ldn     = dataWr && (idxQ == IDX_LDN);
    stb.pwrDir  = dataWr && (idxQ == IDX_PWRDIR);
    stb.pwrAuto = dataWr && (idxQ == IDX_PWRAUTO);
    stb.softRst = dataWr && (idxQ == IDX_SOFTRST) && ioWrData[0];
    stb.devEn   = dataWr && devSel && (idxQ == IDX_DEVEN);
    stb.baseHi  = dataWr && devSel && (idxQ == IDX_BASEHI);
    stb.baseLo  = dataWr && devSel && (idxQ == IDX_BASELO);
    stb.devMode = dataWr && devSel && (idxQ == IDX_MODE);
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LPT_LDN     = 8'h03,
  parameter logic [7:0] BASE_HI_RST = 8'h03,
  parameter logic [7:0] BASE_LO_RST = 8'h78,
  parameter logic [7:0] MODE_RST    = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStb_t     stb,
  input  logic [7:0]  wrData,
  input  logic [7:0]  index,
  input  logic        unlocked,
  input  logic        cfgRead,
  input  logic        dataRead,
  output logic [7:0]  rdData,
  output logic        devSel,
  output logic        softRstPend,
  output logic        devEnable,
  output logic [15:0] devBase,
  output logic [7:0]  devMode
);

  logic                    pendQ;
  logic [7:0]              ldnQ, baseHiQ, baseLoQ, modeQ;
  logic                    enQ;
  logic [NUM_PWR-1:0][7:0] pwrVal;
  logic [NUM_PWR-1:0]      pwrStb;

  assign pwrStb = {stb.pwrAuto, stb.pwrDir};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= stb.softRst && !pendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldnQ    <= 8'h00;
      enQ     <= 1'b0;
      baseHiQ <= BASE_HI_RST;
      baseLoQ <= BASE_LO_RST;
      modeQ   <= MODE_RST;
    end else if (pendQ) begin
      ldnQ    <= 8'h00;
      enQ     <= 1'b0;
      baseHiQ <= BASE_HI_RST;
      baseLoQ <= BASE_LO_RST;
      modeQ   <= MODE_RST;
    end else begin
      if (stb.ldn)     ldnQ    <= wrData;
      if (stb.devEn)   enQ     <= wrData[0];
      if (stb.baseHi)  baseHiQ <= wrData;
      if (stb.baseLo)  baseLoQ <= wrData;
      if (stb.devMode) modeQ   <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_PWR; g++) begin : gPwr
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          q <= 8'h00;
      else if (pendQ)     q <= 8'h00;
      else if (pwrStb[g]) q <= wrData;
    end
    assign pwrVal[g] = q;
  end

  assign devSel      = (ldnQ == LPT_LDN);
  assign softRstPend = pendQ;
  assign devEnable   = enQ;
  assign devBase     = {baseHiQ, baseLoQ};
  assign devMode     = modeQ;

  always_comb begin
    rdData = 8'h00;
    if (cfgRead) begin
      rdData = unlocked ? index : 8'hFF;
    end else if (dataRead) begin
      if (!unlocked) begin
        rdData = 8'hFF;
      end else begin
        case (index)
          IDX_SOFTRST: rdData = {7'd0, pendQ};
          IDX_LDN:     rdData = ldnQ;
          IDX_PWRDIR:  rdData = pwrVal[0];
          IDX_PWRAUTO: rdData = pwrVal[1];
          IDX_DEVEN:   rdData = devSel ? {7'd0, enQ} : 8'h00;
          IDX_BASEHI:  rdData = devSel ? baseHiQ : 8'h00;
          IDX_BASELO:  rdData = devSel ? baseLoQ : 8'h00;
          IDX_MODE:    rdData = devSel ? modeQ : 8'h00;
          default:     rdData = 8'h00;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT    = 16'h03F0,
  parameter logic [7:0]       KEY_A       = 8'h51,
  parameter logic [7:0]       KEY_B       = 8'h23,
  parameter logic [7:0]       KEY_EXIT    = 8'hBB,
  parameter logic [7:0]       LPT_LDN     = 8'h03,
  parameter logic [7:0]       BASE_HI_RST = 8'h03,
  parameter logic [7:0]       BASE_LO_RST = 8'h78,
  parameter logic [7:0]       MODE_RST    = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              lptEnable,
  output logic [15:0]       lptBase,
  output logic [7:0]        lptMode
);

  regStb_t    stb;
  logic       unlocked, cfgRead, dataRead, devSel, softRstPend;
  logic [7:0] index;

  sio_cfg_ctrl #(
    .ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT),
    .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_EXIT(KEY_EXIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .devSel(devSel), .stb(stb), .unlocked(unlocked),
    .cfgRead(cfgRead), .dataRead(dataRead), .index(index)
  );

  sio_cfg_regs #(
    .LPT_LDN(LPT_LDN), .BASE_HI_RST(BASE_HI_RST),
    .BASE_LO_RST(BASE_LO_RST), .MODE_RST(MODE_RST)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(ioWrData), .index(index),
    .unlocked(unlocked), .cfgRead(cfgRead), .dataRead(dataRead),
    .rdData(ioRdData), .devSel(devSel), .softRstPend(softRstPend),
    .devEnable(lptEnable), .devBase(lptBase), .devMode(lptMode)
  );

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker #(
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CFG_PORT    = 16'h03F0,
  parameter logic [7:0]       KEY_B       = 8'h23,
  parameter logic [7:0]       KEY_EXIT    = 8'hBB,
  parameter logic [7:0]       BASE_HI_RST = 8'h03,
  parameter logic [7:0]       BASE_LO_RST = 8'h78,
  parameter logic [7:0]       MODE_RST    = 8'h00
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic              lptEnable,
  input logic [15:0]       lptBase,
  input logic [7:0]        lptMode,
  input logic              unlocked,
  input logic              softRstPend
);

  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(CFG_PORT + 1);

  logic winHit;
  assign winHit = (ioAddr == CFG_PORT) || (ioAddr == DATA_PORT);

  // R2: opening only follows the second key byte at the config address
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(ioWr && ioAddr == CFG_PORT && ioWrData == KEY_B));

  // R3: exit byte locks
  a_r3_exit_locks: assert property (@(posedge clk) disable iff (!rstN)
    unlocked && ioWr && ioAddr == CFG_PORT && ioWrData == KEY_EXIT |=> !unlocked);

  // R4: locked data writes leave outputs untouched
  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked && !softRstPend && ioWr && ioAddr == DATA_PORT
      |=> $stable(lptEnable) && $stable(lptBase) && $stable(lptMode));

  // R4: locked reads of the window return all ones
  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked && ioRd && winHit |-> ioRdData == 8'hFF);

  // R7: enable only moves while the window is open
  a_r7_enable_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lptEnable) |-> $past(unlocked));

  // R11: pending soft reset clears after one cycle
  a_r11_pend_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    softRstPend |=> !softRstPend);

  // R11: pending soft reset restores device defaults
  a_r11_pend_defaults: assert property (@(posedge clk) disable iff (!rstN)
    softRstPend |=> !lptEnable && lptBase == {BASE_HI_RST, BASE_LO_RST}
                    && lptMode == MODE_RST);

  // R13: no read, no data
  a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdData == 8'h00);

endmodule

bind sio_cfg_port sio_cfg_checker #(
  .ADDR_W(ADDR_W), .CFG_PORT(CFG_PORT), .KEY_B(KEY_B), .KEY_EXIT(KEY_EXIT),
  .BASE_HI_RST(BASE_HI_RST), .BASE_LO_RST(BASE_LO_RST), .MODE_RST(MODE_RST)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioWrData(ioWrData), .ioRdData(ioRdData), .lptEnable(lptEnable),
  .lptBase(lptBase), .lptMode(lptMode), .unlocked(unlocked),
  .softRstPend(softRstPend)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CFGA = 16'h03F0;
  localparam logic [15:0] DATA = 16'h03F1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        lptEnable;
  logic [15:0] lptBase;
  logic [7:0]  lptMode;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .lptEnable(lptEnable),
    .lptBase(lptBase), .lptMode(lptMode)
  );

  // reference model state
  bit       mUnl, mArm, mEn;
  bit [7:0] mIdx, mLdn, mPwrD, mPwrA, mHi, mLo, mMode;

  function automatic void modelDefaults();
    mLdn = 8'h00; mPwrD = 8'h00; mPwrA = 8'h00;
    mEn = 1'b0; mHi = 8'h03; mLo = 8'h78; mMode = 8'h00;
  endfunction

  // returns 1 when the write starts a soft reset
  function automatic bit modelWrite(logic [15:0] a, logic [7:0] d);
    bit sr = 0;
    if (a == CFGA) begin
      if (mUnl) begin
        if (d == 8'hBB) mUnl = 0; else mIdx = d;
      end else if (mArm && d == 8'h23) begin
        mUnl = 1; mArm = 0;
      end else begin
        mArm = (d == 8'h51);
      end
    end else if (a == DATA && mUnl) begin
      case (mIdx)
        8'h02: sr = d[0];
        8'h07: mLdn = d;
        8'h22: mPwrD = d;
        8'h23: mPwrA = d;
        8'h30: if (mLdn == 8'h03) mEn = d[0];
        8'h60: if (mLdn == 8'h03) mHi = d;
        8'h61: if (mLdn == 8'h03) mLo = d;
        8'hF0: if (mLdn == 8'h03) mMode = d;
        default: ;
      endcase
    end
    return sr;
  endfunction

  function automatic logic [7:0] modelRead(logic [15:0] a);
    if (a == CFGA) return mUnl ? mIdx : 8'hFF;
    if (a != DATA) return 8'h00;
    if (!mUnl) return 8'hFF;
    case (mIdx)
      8'h07: return mLdn;
      8'h22: return mPwrD;
      8'h23: return mPwrA;
      8'h30: return (mLdn == 8'h03) ? {7'd0, mEn} : 8'h00;
      8'h60: return (mLdn == 8'h03) ? mHi : 8'h00;
      8'h61: return (mLdn == 8'h03) ? mLo : 8'h00;
      8'hF0: return (mLdn == 8'h03) ? mMode : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWrite(logic [15:0] a, logic [7:0] d);
    bit sr;
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    sr = modelWrite(a, d);
    if (sr) begin
      @(negedge clk);
      modelDefaults();
    end
  endtask

  task automatic ioRead(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #(CLK_PERIOD/4);
    v = ioRdData;
    ioRd = 1'b0;
  endtask

  task automatic regWrite(logic [7:0] idx, logic [7:0] d);
    ioWrite(CFGA, idx);
    ioWrite(DATA, d);
  endtask

  task automatic regRead(string req, logic [7:0] idx, logic [7:0] exp);
    logic [7:0] v;
    ioWrite(CFGA, idx);
    ioRead(DATA, v);
    chk(req, v, exp);
  endtask

  task automatic checkPorts(string req);
    chk({req, " enable"}, lptEnable, mEn);
    chk({req, " base"}, lptBase, {mHi, mLo});
    chk({req, " mode"}, lptMode, mMode);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    mUnl = 0; mArm = 0; mIdx = 0; modelDefaults();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 enable", lptEnable, 1'b0);
    chk("R1 base", lptBase, 16'h0378);
    chk("R1 mode", lptMode, 8'h00);
    ioRead(DATA, v); chk("R4 locked data read", v, 8'hFF);
    ioRead(CFGA, v); chk("R4 locked cfg read", v, 8'hFF);

    // R4 locked write ignored
    ioWrite(DATA, 8'hFF);
    checkPorts("R4 locked write");

    // R2 broken pair stays locked
    ioWrite(CFGA, 8'h51); ioWrite(CFGA, 8'h12); ioWrite(CFGA, 8'h23);
    ioRead(CFGA, v); chk("R2 broken pair", v, 8'hFF);
    // R2 0x51 re-arms, other addresses do not break the pair
    ioWrite(CFGA, 8'h51); ioWrite(CFGA, 8'h51); ioWrite(16'h0378, 8'h00);
    ioWrite(CFGA, 8'h23);
    ioRead(CFGA, v); chk("R2 R5 opened index", v, 8'h00);

    // R6 / R7
    regWrite(8'h07, 8'h03);
    regRead("R6 ldn", 8'h07, 8'h03);
    regWrite(8'h30, 8'hFF);
    chk("R7 enable out", lptEnable, 1'b1);
    regRead("R7 enable read", 8'h30, 8'h01);
    // R9 / R8
    regWrite(8'hF0, 8'h8F);
    chk("R9 mode out", lptMode, 8'h8F);
    regWrite(8'h60, 8'h02); regWrite(8'h61, 8'hBC);
    chk("R8 base out", lptBase, 16'h02BC);
    regRead("R8 base lo", 8'h61, 8'hBC);
    // R7 other device
    regWrite(8'h07, 8'h01);
    regWrite(8'h30, 8'h00);
    chk("R7 other ldn write", lptEnable, 1'b1);
    regRead("R7 other ldn read", 8'h30, 8'h00);
    // R10
    regWrite(8'h22, 8'hA5); regWrite(8'h23, 8'h5A);
    regRead("R10 direct", 8'h22, 8'hA5);
    regRead("R10 auto", 8'h23, 8'h5A);
    // R12
    regWrite(8'h41, 8'hFF);
    regRead("R12 unimpl", 8'h41, 8'h00);
    // R13
    ioRead(16'h0378, v); chk("R13 other addr", v, 8'h00);
    // R3 lock keeps index
    ioWrite(CFGA, 8'hBB);
    ioRead(DATA, v); chk("R3 locked read", v, 8'hFF);
    ioWrite(CFGA, 8'h51); ioWrite(CFGA, 8'h23);
    ioRead(CFGA, v); chk("R3 index kept", v, 8'h41);

    // R11 soft reset
    regWrite(8'h07, 8'h03);
    regWrite(8'h02, 8'h00);
    chk("R11 no-op base", lptBase, 16'h02BC);
    ioWrite(CFGA, 8'h02);
    @(negedge clk);
    ioAddr = DATA; ioWrData = 8'h01; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b1;
    #(CLK_PERIOD/4);
    chk("R11 pending read", ioRdData, 8'h01);
    ioRd = 1'b0;
    @(negedge clk);
    modelDefaults();
    checkPorts("R11 defaults");
    ioRead(CFGA, v); chk("R11 still open", v, 8'h02);
    regRead("R11 ldn cleared", 8'h07, 8'h00);
    regRead("R11 pwr cleared", 8'h22, 8'h00);

    // random traffic
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      if (r < 7) begin
        ioWrite(CFGA, 8'h51);
        ioWrite(CFGA, ($urandom % 4 == 0) ? 8'($urandom) : 8'h23);
      end else if (r < 10) begin
        ioWrite(CFGA, 8'hBB);
      end else if (r < 38) begin
        logic [7:0] pool [9] = '{8'h02, 8'h07, 8'h22, 8'h23, 8'h30, 8'h60,
                                 8'h61, 8'hF0, 8'h00};
        logic [7:0] x = pool[$urandom % 9];
        if (x == 8'h00) x = 8'($urandom);
        ioWrite(CFGA, x);
      end else if (r < 62) begin
        logic [7:0] d = 8'($urandom);
        if (mIdx == 8'h07 && ($urandom % 5 < 3)) d = 8'h03;
        if (mIdx == 8'h02 && ($urandom % 4 != 0)) d[0] = 1'b0;
        ioWrite(DATA, d);
      end else if (r < 92) begin
        logic [15:0] a = ($urandom % 2) ? DATA : CFGA;
        ioRead(a, v);
        chk((a == CFGA) ? "R5 rand cfg read" : "R5 rand data read", v, modelRead(a));
      end else begin
        logic [15:0] a = 16'h03F2 + 16'($urandom % 8);
        if ($urandom % 2) begin
          ioWrite(a, 8'($urandom));
        end else begin
          ioRead(a, v);
          chk("R13 rand other read", v, 8'h00);
        end
      end
      checkPorts("R7 R8 R9 rand ports");
    end

    finishRun();
  end

endmodule